// File: doc/BRIEF.md
# Reset Exit Boot Sequencer

This block brings a chip out of reset after power-up. It holds every reset output asserted while the supply is below threshold or the regulated rails are not yet safe. Once both conditions are met, it steps through a fixed release order. First it starts the clock generator. Next it turns on the core, system, flash and ungated bus clocks. Then it frees the flash controller while the external reset pin is still pulled low for a fixed number of bus cycles. Finally it waits for the flash to report that initialization is done, and only then lets the core out of reset.

Two option bits, latched when the reset pin is released, set up the starting point for the rest of the chip. One bit selects a slow low-power set of clock divider codes or a full-speed set. The other bit decides whether the active-low boot-select pin is allowed to steer the chip into its serial programming port. A loss of either supply input throws the sequence back to its static power-on state at once.

Top module: `boot_exit_seq`

## Requirements
- R1: While `supply_ok` is low, the block sits in its static power-on state. In that state `sys_rst`, `rst_pin_drive_low` and `flash_rst` are 1, all clock enables and `clkgen_en` are 0, the dividers show the slow preset (7, 7, F) and `boot_serial` is 0.
- R2: With `supply_ok` high but `vreg_safe` low, the block stays in that same static state for as long as `vreg_safe` stays low.
- R3: On the first clock edge with both supply inputs high, `clkgen_en` rises while the clock enables stay off and all resets stay asserted.
- R4: On the next edge, `core_clk_en`, `sys_clk_en`, `flash_clk_en` and every bit of `bus_clk_en` turn on, and they stay on until the next power-on state.
- R5: On the edge after that, `flash_rst` falls while `sys_rst` stays 1. From there `rst_pin_drive_low` stays 1 for exactly HOLD_CYCLES (128) clocks.
- R6: After the pin is released, `sys_rst` stays 1 until `flash_init_done` is seen high at a clock edge. A `flash_init_done` that arrives before the pin is released has no effect until then.
- R7: `boot_serial` is 0 whenever the latched port-enable option bit (`boot_opt[1]`) is 0. When that bit is 1, `bootsel_n` is sampled at the edge where `sys_rst` is released: a low pin gives `boot_serial` = 1 and a high pin gives 0.
- R8: When the latched speed bit (`boot_opt[0]`) is 0, the divider codes are core 0x7, bus 0x7 and flash 0xF.
- R9: When the latched speed bit is 1, the divider codes are core 0x0, bus 0x0 and flash 0x1.
- R10: `boot_opt` is captured at the edge that releases the reset pin, and `bootsel_n` is captured at the edge that releases `sys_rst`. Later changes to either input do not move the dividers or `boot_serial` until the next power-on state.
- R11: A fall of `supply_ok` returns the block to the R1 state asynchronously. A low `vreg_safe` at a clock edge returns it to that state at that edge. After either, the full sequence restarts from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock that times every phase |
| supply_ok | input | 1 | Supply is above the power-on threshold; low acts as an asynchronous reset |
| vreg_safe | input | 1 | Regulated internal supplies have reached a safe level |
| flash_init_done | input | 1 | Flash controller has finished its initialization |
| bootsel_n | input | 1 | Active-low boot-select pin for the serial programming port |
| boot_opt | input | 2 | Option bits: [0] full-speed dividers, [1] programming-port enable |
| sys_rst | output | 1 | Internal system reset, active high |
| rst_pin_drive_low | output | 1 | Open-drain reset pin drive: 1 pulls the pin low |
| clkgen_en | output | 1 | Enables the clock generator in its default mode |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| bus_clk_en | output | BUS_CLKS | Enables for the bus clocks that have no gating control |
| flash_rst | output | 1 | Flash controller reset, active high |
| div_core | output | 4 | Core/system clock divider code |
| div_bus | output | 4 | Bus clock divider code |
| div_flash | output | 4 | Flash clock divider code |
| boot_serial | output | 1 | 1 selects the serial programming port, 0 normal CPU boot |

## Verification
The embedded assertions watch the release order on every cycle. Clocks may only come on while the clock generator is running. The flash controller may only leave reset while the pin and the system reset are still held. The pin may only be released when the hold timer reports completion. The system reset may only fall after the pin is free and the flash has reported done. The assertions also check that a low regulator input forces the power-on state at the next edge, and that the latched option bits do not move once they are settled.

The exact hold length, the divider codes for each option setting, the sampling of the boot-select pin, the ignoring of an early flash-done and of late option changes, and the restart after a supply loss in the middle of the hold are all shown by the bench's scenarios. There, a behavioural model is compared with every output on every clock.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int unsigned DIV_W        = 4;
    localparam int unsigned OPT_W        = 2;
    localparam int unsigned OPT_FAST_BIT = 0;
    localparam int unsigned OPT_PORT_BIT = 1;

    typedef enum logic [2:0] {
        PH_POR    = 3'd0,
        PH_CLKGEN = 3'd1,
        PH_CLKON  = 3'd2,
        PH_FLASH  = 3'd3,
        PH_WAITFL = 3'd4,
        PH_RUN    = 3'd5
    } phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] core;
        logic [DIV_W-1:0] bus;
        logic [DIV_W-1:0] flash;
    } div_set_t;

    localparam div_set_t DIV_SLOW = '{core: DIV_W'(7), bus: DIV_W'(7), flash: DIV_W'(15)};
    localparam div_set_t DIV_FAST = '{core: DIV_W'(0), bus: DIV_W'(0), flash: DIV_W'(1)};

    function automatic div_set_t div_preset(input logic fast);
        return fast ? DIV_FAST : DIV_SLOW;
    endfunction

endpackage

// File: rtl/boot_hold_timer.sv
module boot_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 128
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        done  = run && (cur_q.cnt == LAST);
        if (!run || done) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cur_q.cnt <= LAST);

    // R5
    idle_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !run |=> cur_q.cnt == '0);

endmodule

// File: rtl/boot_cfg_latch.sv
module boot_cfg_latch
    import boot_seq_pkg::*;
(
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clr,
    input  logic             cap_opt,
    input  logic             cap_mode,
    input  logic [OPT_W-1:0] opt,
    input  logic             bootsel_n,
    output div_set_t         divs,
    output logic             boot_serial
);
    typedef struct packed {
        logic fast;
        logic port_en;
        logic serial;
        logic settled;
    } cfg_t;

    cfg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr) begin
            nxt_d = '0;
        end else begin
            if (cap_opt) begin
                nxt_d.fast    = opt[OPT_FAST_BIT];
                nxt_d.port_en = opt[OPT_PORT_BIT];
                nxt_d.settled = 1'b1;
            end
            if (cap_mode) begin
                nxt_d.serial = cur_q.port_en & ~bootsel_n;
            end
        end
        divs        = div_preset(cur_q.fast);
        boot_serial = cur_q.serial;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R7
    port_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !cur_q.port_en |-> !boot_serial);

    // R10
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (cur_q.settled && !clr && !cap_opt) |=> $stable(divs) && $stable(cur_q.port_en));

endmodule

// File: rtl/boot_exit_seq.sv
module boot_exit_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 128,
    parameter int unsigned BUS_CLKS    = 2
) (
    input  logic                clk,
    input  logic                supply_ok,
    input  logic                vreg_safe,
    input  logic                flash_init_done,
    input  logic                bootsel_n,
    input  logic [OPT_W-1:0]    boot_opt,
    output logic                sys_rst,
    output logic                rst_pin_drive_low,
    output logic                clkgen_en,
    output logic                core_clk_en,
    output logic                sys_clk_en,
    output logic                flash_clk_en,
    output logic [BUS_CLKS-1:0] bus_clk_en,
    output logic                flash_rst,
    output logic [DIV_W-1:0]    div_core,
    output logic [DIV_W-1:0]    div_bus,
    output logic [DIV_W-1:0]    div_flash,
    output logic                boot_serial
);
    typedef struct packed {
        phase_e ph;
    } seq_t;

    seq_t     cur_q, nxt_d;
    logic     hold_run, hold_done;
    logic     cap_opt, cap_mode, clr_cfg;
    logic     clocks_on;
    div_set_t divs;

    boot_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .arst_n (supply_ok),
        .run    (hold_run),
        .done   (hold_done)
    );

    boot_cfg_latch u_cfg (
        .clk         (clk),
        .arst_n      (supply_ok),
        .clr         (clr_cfg),
        .cap_opt     (cap_opt),
        .cap_mode    (cap_mode),
        .opt         (boot_opt),
        .bootsel_n   (bootsel_n),
        .divs        (divs),
        .boot_serial (boot_serial)
    );

    always_comb begin
        nxt_d    = cur_q;
        hold_run = 1'b0;
        cap_opt  = 1'b0;
        cap_mode = 1'b0;
        unique case (cur_q.ph)
            PH_POR:    nxt_d.ph = PH_CLKGEN;
            PH_CLKGEN: nxt_d.ph = PH_CLKON;
            PH_CLKON:  nxt_d.ph = PH_FLASH;
            PH_FLASH: begin
                hold_run = 1'b1;
                if (hold_done) begin
                    nxt_d.ph = PH_WAITFL;
                    cap_opt  = 1'b1;
                end
            end
            PH_WAITFL: begin
                if (flash_init_done) begin
                    nxt_d.ph = PH_RUN;
                    cap_mode = 1'b1;
                end
            end
            PH_RUN:    nxt_d.ph = PH_RUN;
            default:   nxt_d.ph = PH_POR;
        endcase
        if (!supply_ok || !vreg_safe) begin
            nxt_d.ph = PH_POR;
            hold_run = 1'b0;
            cap_opt  = 1'b0;
            cap_mode = 1'b0;
        end
        clr_cfg = (nxt_d.ph == PH_POR);
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            cur_q <= '{ph: PH_POR};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        sys_rst           = (cur_q.ph != PH_RUN);
        rst_pin_drive_low = (cur_q.ph == PH_POR) || (cur_q.ph == PH_CLKGEN) ||
                            (cur_q.ph == PH_CLKON) || (cur_q.ph == PH_FLASH);
        clkgen_en         = (cur_q.ph != PH_POR);
        clocks_on         = clkgen_en && (cur_q.ph != PH_CLKGEN);
        flash_rst         = (cur_q.ph == PH_POR) || (cur_q.ph == PH_CLKGEN) ||
                            (cur_q.ph == PH_CLKON);
        core_clk_en       = clocks_on;
        sys_clk_en        = clocks_on;
        flash_clk_en      = clocks_on;
        bus_clk_en        = {BUS_CLKS{clocks_on}};
        div_core          = divs.core;
        div_bus           = divs.bus;
        div_flash         = divs.flash;
    end

    // R3
    phase1_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(clkgen_en) |-> !core_clk_en && flash_rst && sys_rst);

    // R4
    clk_order_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        (core_clk_en || flash_clk_en) |-> clkgen_en);

    // R5
    flash_early_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(flash_rst) |-> rst_pin_drive_low && sys_rst);

    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(rst_pin_drive_low) |-> $past(hold_done));

    // R6
    rel_order_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(sys_rst) |-> !rst_pin_drive_low && !flash_rst && $past(flash_init_done));

    // R11
    vreg_drop_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        !vreg_safe |=> sys_rst && rst_pin_drive_low && flash_rst && !clkgen_en);

endmodule

// File: tb/boot_exit_seq_test.sv
module boot_exit_seq_test;
    import boot_seq_pkg::*;

    localparam int HOLD = 128;
    localparam int NB   = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          supply_ok = 1'b0, vreg_safe = 1'b0, flash_init_done = 1'b0, bootsel_n = 1'b1;
    logic [1:0]    boot_opt = 2'b00;
    logic          sys_rst, rst_pin_drive_low, clkgen_en, core_clk_en, sys_clk_en, flash_clk_en;
    logic [NB-1:0] bus_clk_en;
    logic          flash_rst, boot_serial;
    logic [3:0]    div_core, div_bus, div_flash;

    boot_exit_seq #(.HOLD_CYCLES(HOLD), .BUS_CLKS(NB)) uut (
        .clk(clk), .supply_ok(supply_ok), .vreg_safe(vreg_safe),
        .flash_init_done(flash_init_done), .bootsel_n(bootsel_n), .boot_opt(boot_opt),
        .sys_rst(sys_rst), .rst_pin_drive_low(rst_pin_drive_low), .clkgen_en(clkgen_en),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .flash_clk_en(flash_clk_en),
        .bus_clk_en(bus_clk_en), .flash_rst(flash_rst), .div_core(div_core),
        .div_bus(div_bus), .div_flash(div_flash), .boot_serial(boot_serial)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference: phase number 0..5, hold count, latched options
    int m_ph  = 0;
    int m_cnt = 0;
    bit m_fast = 0, m_port = 0, m_ser = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (!supply_ok || !vreg_safe) begin
            m_ph = 0; m_cnt = 0; m_fast = 0; m_port = 0; m_ser = 0;
        end else begin
            case (m_ph)
                0: m_ph = 1;
                1: m_ph = 2;
                2: begin m_ph = 3; m_cnt = 0; end
                3: begin
                    if (m_cnt == HOLD - 1) begin
                        m_ph = 4; m_fast = boot_opt[0]; m_port = boot_opt[1];
                    end else m_cnt++;
                end
                4: if (flash_init_done) begin m_ph = 5; m_ser = m_port && !bootsel_n; end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        chk("R6 sys_rst", 32'(sys_rst), 32'(m_ph != 5));
        chk("R5 reset pin", 32'(rst_pin_drive_low), 32'(m_ph <= 3));
        chk("R3 clkgen_en", 32'(clkgen_en), 32'(m_ph >= 1));
        chk("R4 clock enables", 32'({core_clk_en, sys_clk_en, flash_clk_en, bus_clk_en}),
            (m_ph >= 2) ? 32'((1 << (3 + NB)) - 1) : 32'd0);
        chk("R5 flash_rst", 32'(flash_rst), 32'(m_ph <= 2));
        if (m_fast) chk("R9 dividers", 32'({div_core, div_bus, div_flash}), 32'h001);
        else        chk("R8 dividers", 32'({div_core, div_bus, div_flash}), 32'h77F);
        chk("R7 boot mode", 32'(boot_serial), 32'(m_ser));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic check_por(input string tag);
        chk(tag, 32'({sys_rst, rst_pin_drive_low, flash_rst, clkgen_en, core_clk_en,
                      boot_serial, div_core, div_bus, div_flash}),
            32'({6'b111000, 12'h77F}));
    endtask

    // called two cycles after leaving the power-on state; ends when the pin is released
    task automatic run_hold();
        int n = 0;
        for (int g = 0; g < 4 * HOLD; g++) begin
            cycle();
            if (!flash_rst && rst_pin_drive_low) n++;
            if (!rst_pin_drive_low) break;
        end
        chk("R5 pin hold length", 32'(n), 32'(HOLD));
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // scenario 1: slow dividers, port disabled, early flash done
        repeat (4) cycle();
        check_por("R1 supply low");
        supply_ok = 1'b1;
        repeat (5) cycle();
        check_por("R2 vreg low");
        boot_opt = 2'b00; bootsel_n = 1'b0; flash_init_done = 1'b1; vreg_safe = 1'b1;
        cycle();
        chk("R3 clkgen first", 32'(clkgen_en), 32'd1);
        chk("R3 clocks off", 32'(core_clk_en), 32'd0);
        cycle();
        chk("R4 clocks on", 32'(core_clk_en && sys_clk_en && flash_clk_en && &bus_clk_en), 32'd1);
        run_hold();
        chk("R6 early done ignored", 32'(sys_rst), 32'd1);
        cycle();
        chk("R6 release", 32'(sys_rst), 32'd0);
        chk("R7 port disabled", 32'(boot_serial), 32'd0);
        chk("R8 slow preset", 32'({div_core, div_bus, div_flash}), 32'h77F);
        boot_opt = 2'b11;
        repeat (3) cycle();
        chk("R10 opt change ignored", 32'({boot_serial, div_core, div_bus, div_flash}), 32'h077F);

        // scenario 2: async supply loss, fast dividers, serial port selected
        supply_ok = 1'b0;
        #1;
        check_por("R11 supply drop");
        repeat (3) cycle();
        supply_ok = 1'b1; boot_opt = 2'b11; bootsel_n = 1'b0; flash_init_done = 1'b0;
        repeat (2) cycle();
        run_hold();
        repeat (20) cycle();
        chk("R6 waits for flash", 32'(sys_rst), 32'd1);
        boot_opt = 2'b00;
        flash_init_done = 1'b1;
        cycle();
        chk("R6 release after done", 32'(sys_rst), 32'd0);
        chk("R7 serial selected", 32'(boot_serial), 32'd1);
        chk("R9 fast preset", 32'({div_core, div_bus, div_flash}), 32'h001);
        bootsel_n = 1'b1;
        repeat (3) cycle();
        chk("R10 pin change ignored", 32'(boot_serial), 32'd1);

        // scenario 3: regulator loss in running state and in the middle of the hold
        vreg_safe = 1'b0;
        cycle();
        check_por("R11 vreg drop in run");
        vreg_safe = 1'b1; boot_opt = 2'b10; bootsel_n = 1'b1; flash_init_done = 1'b0;
        repeat (2) cycle();
        repeat (50) cycle();
        vreg_safe = 1'b0;
        cycle();
        check_por("R11 vreg drop in hold");
        vreg_safe = 1'b1;
        repeat (2) cycle();
        run_hold();
        flash_init_done = 1'b1;
        cycle();
        chk("R7 pin high gives normal", 32'(boot_serial), 32'd0);
        chk("R8 slow preset again", 32'({div_core, div_bus, div_flash}), 32'h77F);

        // scenario 4: fast dividers with port disabled and pin low
        supply_ok = 1'b0;
        repeat (2) cycle();
        supply_ok = 1'b1; boot_opt = 2'b01; bootsel_n = 1'b0; flash_init_done = 1'b1;
        repeat (2) cycle();
        run_hold();
        cycle();
        chk("R7 pin ignored", 32'(boot_serial), 32'd0);
        chk("R9 fast no port", 32'({div_core, div_bus, div_flash}), 32'h001);
        repeat (4) cycle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule